// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames as a byte stream and stores each one in a circular receive buffer of 16384 bytes. For every stored frame it fills one entry of a 64-slot descriptor ring with the frame length and the buffer location, raises a one-cycle receive-end interrupt, and counts the frame. Software drains the stored bytes either one 32-bit word per read of a data port or as a burst of words on a DMA output. It then returns descriptor slots by setting their empty flag again and lowers the frame count through a decrement register.

A frame is taken only if three things are true when its first byte arrives: the current descriptor slot is marked empty, fewer than 64 frames are outstanding, and the worst-case frame of 1514 bytes still fits in the buffer. A refused frame is dropped in full and leaves no trace.

The receive side runs a four-state machine. RX_IDLE waits for a first byte and goes to RX_STORE (frame admitted, more bytes follow), RX_COMMIT (admitted one-byte frame) or RX_DROP (refused, more bytes follow). A refused one-byte frame stays in RX_IDLE. RX_STORE goes to RX_COMMIT on the last byte. RX_DROP goes back to RX_IDLE on the last byte. RX_COMMIT always returns to RX_IDLE after one cycle, writing the descriptor and updating the pointers. A soft reset sends an open frame to RX_DROP and any other state to RX_IDLE. The host side has two states. H_IDLE moves to H_DMA when a burst is started while DMA is enabled. H_DMA returns to H_IDLE after the last word, or at once on a soft reset.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: While the frame count equals 64, a starting frame is refused: no byte is stored, the write pointer, count and descriptor index stay as they are, and no interrupt is raised.
- R2: A starting frame is refused when (write pointer − read pointer) mod 16384 exceeds 16384 − 1514 = 14870. A difference of zero counts as a fully free buffer.
- R3: If bit 15 (empty) of the current descriptor's control word is clear, the starting frame is dropped and no pointer, count, index or interrupt changes.
- R4: On acceptance the current descriptor's word 1 becomes {pointer[31:16] = 0x4000 + start offset, length[15:0] = true byte count}, and bit 15 of its control word is cleared.
- R5: After an accepted frame the write pointer equals start offset + the length rounded up to a multiple of 4, modulo 16384.
- R6: After an accepted frame the descriptor index advances modulo 64, the count rises by one, and rx_irq is high for exactly one cycle, the second cycle after the last byte.
- R7: A read of register 6 (data port) returns the buffer word at the read pointer and advances the read pointer by 4, modulo 16384.
- R8: A write of N (N > 0, wdata[15:0]) to register 7 while control bit 1 (DMA enable) is set streams N words from the read pointer on dma_data in consecutive cycles with dma_valid high, advances the read pointer by 4N and clears control bit 1. While control bit 1 is clear, the write has no effect.
- R9: Any write to register 2 lowers the count by one, but never below zero. An increment and a decrement in the same cycle leave the count unchanged.
- R10: Writing 1 to control bit 0 (register 0) clears the descriptor index, write pointer, read pointer and count, and sets register 5 (size) to 16384. Bit 0 always reads back as 0.
- R11: Frame byte k is stored at buffer offset start + k. Within a word, offset mod 4 selects the byte lane, with lane 0 in bits 7:0.
- R12: After reset all counters and pointers read 0, size reads 0, all descriptor words read 0, and rx_irq and dma_valid are low.

Register map (host_addr is a word address): bit 7 clear selects a register by bits 2:0. The registers are 0 control, 1 count, 2 decrement, 3 read pointer, 4 write pointer, 5 size, 6 data port and 7 DMA start. Bit 7 set selects descriptor i = bits 6:1, with bit 0 choosing word 0 ({reserved, control}) or word 1 ({pointer, length}). Read data appears on host_rdata in the cycle after host_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_rd |
| dma_valid | output | 1 | DMA word valid |
| dma_data | output | 32 | DMA word |
| rx_irq | output | 1 | One-cycle receive-end pulse |

## Verification
The assertions assume frames arrive with at least one idle cycle after each last byte, that no frame is longer than 1514 bytes, and that the host makes no access while a DMA burst is running. The bench drives every frame from one task that always leaves idle cycles after the last byte. It uses frame lengths from 1 to 1514 only, and it waits out each burst before touching registers again. The single deliberate overlap is a decrement timed to land on a commit cycle, and this is within the assumptions.

// File: rtl/rdrw_pkg.sv
package rdrw_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STORE,
        RX_DROP,
        RX_COMMIT
    } rx_state_e;

    typedef enum logic {
        H_IDLE,
        H_DMA
    } host_state_e;

    // register word indices
    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_COUNT  = 3'd1;
    localparam logic [2:0] REG_DEC    = 3'd2;
    localparam logic [2:0] REG_RDPTR  = 3'd3;
    localparam logic [2:0] REG_WRPTR  = 3'd4;
    localparam logic [2:0] REG_SIZE   = 3'd5;
    localparam logic [2:0] REG_DATA   = 3'd6;
    localparam logic [2:0] REG_DMAGO  = 3'd7;

    localparam int EMPTY_BIT = 15;

endpackage

// File: rtl/rdrw_admit.sv
module rdrw_admit #(
    parameter int BUF_AW    = 14,
    parameter int CNT_W     = 7,
    parameter int FRAME_CAP = 64,
    parameter int MAX_FRAME = 1514
) (
    input  logic [BUF_AW-1:0] wr_ptr,
    input  logic [BUF_AW-1:0] rd_ptr,
    input  logic [CNT_W-1:0]  frame_cnt,
    input  logic              slot_empty,
    output logic              admit
);
    localparam int BUF_BYTES = 1 << BUF_AW;
    localparam int USED_MAX  = BUF_BYTES - MAX_FRAME;

    logic [BUF_AW-1:0] used;
    logic              room_ok;
    logic              slot_ok;

    always_comb begin
        used    = wr_ptr - rd_ptr;
        // used == 0 means an empty buffer, which always has room
        room_ok = ({1'b0, used} <= (BUF_AW+1)'(USED_MAX));
        slot_ok = (frame_cnt != CNT_W'(FRAME_CAP));
        admit   = room_ok && slot_ok && slot_empty;
    end

endmodule

// File: rtl/rdrw_rxbuf.sv
module rdrw_rxbuf #(
    parameter int BUF_AW = 14
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BUF_AW-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [BUF_AW-3:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int WORDS = (1 << BUF_AW) / 4;

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr[BUF_AW-1:2]][{wr_addr[1:0], 3'b000} +: 8] <= wr_byte;
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/rdrw_desc_ring.sv
module rdrw_desc_ring
    import rdrw_pkg::*;
#(
    parameter int RING  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic             hw_half,
    input  logic [31:0]      hw_data,
    input  logic             cm_en,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic [15:0]      cm_len,
    input  logic [15:0]      cm_ptr,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_half,
    output logic [31:0]      rd_word,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             cur_empty
);
    logic [15:0] ctrl_a [RING];
    logic [15:0] resv_a [RING];
    logic [15:0] len_a  [RING];
    logic [15:0] ptr_a  [RING];

    for (genvar e = 0; e < RING; e++) begin : g_slot
        logic [15:0] ctrl_q, resv_q, len_q, ptr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                resv_q <= '0;
                len_q  <= '0;
                ptr_q  <= '0;
            end else begin
                if (hw_en && hw_idx == IDX_W'(e)) begin
                    if (hw_half) {ptr_q, len_q}   <= hw_data;
                    else         {resv_q, ctrl_q} <= hw_data;
                end
                // frame commit wins over a host write to the same slot
                if (cm_en && cm_idx == IDX_W'(e)) begin
                    len_q             <= cm_len;
                    ptr_q             <= cm_ptr;
                    ctrl_q[EMPTY_BIT] <= 1'b0;
                end
            end
        end

        assign ctrl_a[e] = ctrl_q;
        assign resv_a[e] = resv_q;
        assign len_a[e]  = len_q;
        assign ptr_a[e]  = ptr_q;
    end

    assign rd_word   = rd_half ? {ptr_a[rd_idx], len_a[rd_idx]}
                               : {resv_a[rd_idx], ctrl_a[rd_idx]};
    assign cur_empty = ctrl_a[cur_idx][EMPTY_BIT];

endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
    import rdrw_pkg::*;
#(
    parameter int BUF_AW    = 14,
    parameter int RING      = 64,
    parameter int FRAME_CAP = 64,
    parameter int MAX_FRAME = 1514,
    parameter int LEN_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    input  logic                         host_wr,
    input  logic                         host_rd,
    input  logic [$clog2(RING)+1:0]      host_addr,
    input  logic [31:0]                  host_wdata,
    output logic [31:0]                  host_rdata,
    output logic                         dma_valid,
    output logic [31:0]                  dma_data,
    output logic                         rx_irq
);
    localparam int IDX_W     = $clog2(RING);
    localparam int HA_W      = IDX_W + 2;
    localparam int CNT_W     = $clog2(FRAME_CAP + 1);
    localparam int BUF_BYTES = 1 << BUF_AW;
    localparam int PTR_BASE  = 1 << BUF_AW;

    rx_state_e   rx_state, rx_next;
    host_state_e host_state, host_next;

    logic [BUF_AW-1:0] wr_ptr, rd_ptr, cur_ptr, start_ptr;
    logic [LEN_W-1:0]  frame_len;
    logic [IDX_W-1:0]  desc_idx;
    logic [CNT_W-1:0]  frame_cnt;
    logic [BUF_AW:0]   size_q;
    logic              dma_en;
    logic [15:0]       dma_left;
    logic              slot_empty, admit;
    logic [31:0]       rdata_q, desc_word, buf_word;
    logic              data_sel_q;

    // host decode
    logic             desc_sel;
    logic [2:0]       reg_sel;
    logic             soft_rst, dec_req, data_rd, dma_go, ctrl_wr;

    assign desc_sel = host_addr[HA_W-1];
    assign reg_sel  = host_addr[2:0];
    assign ctrl_wr  = host_wr && !desc_sel && reg_sel == REG_CTRL;
    assign soft_rst = ctrl_wr && host_wdata[0];
    assign dec_req  = host_wr && !desc_sel && reg_sel == REG_DEC;
    assign data_rd  = host_rd && !desc_sel && reg_sel == REG_DATA && host_state == H_IDLE;
    assign dma_go   = host_wr && !desc_sel && reg_sel == REG_DMAGO && dma_en
                      && host_wdata[15:0] != 16'd0 && host_state == H_IDLE;

    // receive-path control
    logic commit_fire, take_first, byte_we;
    logic [LEN_W-1:0] len_pad;

    assign commit_fire = (rx_state == RX_COMMIT) && !soft_rst;
    assign take_first  = (rx_state == RX_IDLE) && in_valid && admit && !soft_rst;
    assign byte_we     = take_first || ((rx_state == RX_STORE) && in_valid && !soft_rst);
    assign len_pad     = (frame_len + LEN_W'(3)) & ~LEN_W'(3);

    rdrw_admit #(
        .BUF_AW(BUF_AW), .CNT_W(CNT_W), .FRAME_CAP(FRAME_CAP), .MAX_FRAME(MAX_FRAME)
    ) u_admit (
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .frame_cnt(frame_cnt),
        .slot_empty(slot_empty), .admit(admit)
    );

    rdrw_rxbuf #(.BUF_AW(BUF_AW)) u_buf (
        .clk(clk),
        .wr_en(byte_we),
        .wr_addr((rx_state == RX_IDLE) ? wr_ptr : cur_ptr),
        .wr_byte(in_data),
        .rd_addr(rd_ptr[BUF_AW-1:2]),
        .rd_data(buf_word)
    );

    rdrw_desc_ring #(.RING(RING), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .hw_en(host_wr && desc_sel),
        .hw_idx(host_addr[IDX_W:1]),
        .hw_half(host_addr[0]),
        .hw_data(host_wdata),
        .cm_en(commit_fire),
        .cm_idx(desc_idx),
        .cm_len(16'(frame_len)),
        .cm_ptr(16'(PTR_BASE) + 16'(start_ptr)),
        .rd_idx(host_addr[IDX_W:1]),
        .rd_half(host_addr[0]),
        .rd_word(desc_word),
        .cur_idx(desc_idx),
        .cur_empty(slot_empty)
    );

    // receive FSM: next state
    always_comb begin
        rx_next = rx_state;
        unique case (rx_state)
            RX_IDLE:
                if (in_valid) begin
                    if (admit) rx_next = in_last ? RX_COMMIT : RX_STORE;
                    else       rx_next = in_last ? RX_IDLE   : RX_DROP;
                end
            RX_STORE:
                if (in_valid && in_last) rx_next = RX_COMMIT;
            RX_DROP:
                if (in_valid && in_last) rx_next = RX_IDLE;
            RX_COMMIT:
                rx_next = RX_IDLE;
        endcase
        if (soft_rst) begin
            if ((rx_state == RX_STORE || rx_state == RX_DROP ||
                 (rx_state == RX_IDLE && in_valid)) && !(in_valid && in_last))
                rx_next = RX_DROP;
            else
                rx_next = RX_IDLE;
        end
    end

    // host FSM: next state
    always_comb begin
        host_next = host_state;
        unique case (host_state)
            H_IDLE: if (dma_go) host_next = H_DMA;
            H_DMA:  if (dma_left == 16'd1) host_next = H_IDLE;
        endcase
        if (soft_rst) host_next = H_IDLE;
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_state   <= RX_IDLE;
            host_state <= H_IDLE;
        end else begin
            rx_state   <= rx_next;
            host_state <= host_next;
        end
    end

    // receive datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            cur_ptr   <= '0;
            start_ptr <= '0;
            frame_len <= '0;
            desc_idx  <= '0;
            rx_irq    <= 1'b0;
        end else begin
            rx_irq <= commit_fire;
            if (take_first) begin
                start_ptr <= wr_ptr;
                cur_ptr   <= wr_ptr + BUF_AW'(1);
                frame_len <= LEN_W'(1);
            end else if (byte_we) begin
                cur_ptr   <= cur_ptr + BUF_AW'(1);
                frame_len <= frame_len + LEN_W'(1);
            end
            if (soft_rst) begin
                wr_ptr   <= '0;
                desc_idx <= '0;
            end else if (commit_fire) begin
                wr_ptr   <= start_ptr + len_pad[BUF_AW-1:0];
                desc_idx <= desc_idx + IDX_W'(1);
            end
        end
    end

    // frame counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (soft_rst) begin
            frame_cnt <= '0;
        end else begin
            unique case ({commit_fire, dec_req && frame_cnt != '0})
                2'b10:   frame_cnt <= frame_cnt + CNT_W'(1);
                2'b01:   frame_cnt <= frame_cnt - CNT_W'(1);
                default: frame_cnt <= frame_cnt;
            endcase
        end
    end

    // host datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            size_q     <= '0;
            dma_en     <= 1'b0;
            dma_left   <= '0;
            dma_valid  <= 1'b0;
            rdata_q    <= '0;
            data_sel_q <= 1'b0;
        end else begin
            dma_valid  <= (host_state == H_DMA) && !soft_rst;
            data_sel_q <= data_rd;
            if (soft_rst) begin
                rd_ptr <= '0;
                size_q <= (BUF_AW+1)'(BUF_BYTES);
            end else if (data_rd || host_state == H_DMA) begin
                rd_ptr <= rd_ptr + BUF_AW'(4);
            end
            if (ctrl_wr)
                dma_en <= host_wdata[1];
            else if (host_state == H_DMA && dma_left == 16'd1)
                dma_en <= 1'b0;
            if (dma_go)
                dma_left <= host_wdata[15:0];
            else if (host_state == H_DMA)
                dma_left <= dma_left - 16'd1;
            if (host_rd) begin
                if (desc_sel) begin
                    rdata_q <= desc_word;
                end else begin
                    unique case (reg_sel)
                        REG_CTRL:  rdata_q <= {30'd0, dma_en, 1'b0};
                        REG_COUNT: rdata_q <= 32'(frame_cnt);
                        REG_RDPTR: rdata_q <= 32'(rd_ptr);
                        REG_WRPTR: rdata_q <= 32'(wr_ptr);
                        REG_SIZE:  rdata_q <= 32'(size_q);
                        default:   rdata_q <= '0;
                    endcase
                end
            end
        end
    end

    assign host_rdata = data_sel_q ? buf_word : rdata_q;
    assign dma_data   = buf_word;

endmodule

// File: rtl/rdrw_chk.sv
module rdrw_chk
    import rdrw_pkg::*;
#(
    parameter int BUF_AW    = 14,
    parameter int CNT_W     = 7,
    parameter int FRAME_CAP = 64
) (
    input logic              clk,
    input logic              rst_n,
    input rx_state_e         rx_state,
    input logic              in_valid,
    input logic              slot_empty,
    input logic [CNT_W-1:0]  frame_cnt,
    input logic [BUF_AW-1:0] wr_ptr,
    input logic [BUF_AW-1:0] rd_ptr,
    input logic [BUF_AW:0]   size_q,
    input logic              soft_rst,
    input logic              rx_irq,
    input logic              dma_valid
);
    localparam int BUF_BYTES = 1 << BUF_AW;

    p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(FRAME_CAP));

    p_refuse_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && in_valid && frame_cnt == CNT_W'(FRAME_CAP))
        |=> (rx_state != RX_STORE && rx_state != RX_COMMIT));

    p_drop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && in_valid && !slot_empty && !soft_rst)
        |=> ($stable(wr_ptr) && !rx_irq));

    p_wr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(rx_state) == RX_COMMIT);

    p_dma_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> rd_ptr == BUF_AW'($past(rd_ptr) + BUF_AW'(4)));

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (frame_cnt == '0 && wr_ptr == '0 && rd_ptr == '0
                      && size_q == (BUF_AW+1)'(BUF_BYTES)));

endmodule

bind rx_desc_ring_writer rdrw_chk #(
    .BUF_AW(BUF_AW), .CNT_W(CNT_W), .FRAME_CAP(FRAME_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_state(rx_state), .in_valid(in_valid),
    .slot_empty(slot_empty), .frame_cnt(frame_cnt), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .size_q(size_q), .soft_rst(soft_rst),
    .rx_irq(rx_irq), .dma_valid(dma_valid)
);

// File: tb/rx_desc_ring_writer_test.sv
module rx_desc_ring_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = 8'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata, dma_data;
    logic        dma_valid, rx_irq;

    int total = 0, bad = 0, irq_seen = 0, dma_n = 0;
    logic [31:0] dma_buf [128];
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_desc_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_valid(dma_valid), .dma_data(dma_data), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        if (rx_irq) irq_seen++;
        if (dma_valid) begin
            if (dma_n < 128) dma_buf[dma_n] = dma_data;
            dma_n++;
        end
    end

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 37 + k * 5 + 1) & 255);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(int addr, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'(addr); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(int addr, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 8'(addr);
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic send(int len, int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(seed, k); in_last = (k == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic arm_all();
        for (int i = 0; i < 64; i++) hwrite(128 + i * 2, 32'h0000_8000);
    endtask

    function automatic int rnd4(int n);
        return (n + 3) & ~3;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_b [64];
        bit          exp_ok [64];
        int s, irq0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        hread(1, v); chk("R12 count", v, 0);
        hread(3, v); chk("R12 rd_ptr", v, 0);
        hread(4, v); chk("R12 wr_ptr", v, 0);
        hread(5, v); chk("R12 size", v, 0);
        hread(128, v); chk("R12 desc0 word0", v, 0);
        chk("R12 irq/dma", {rx_irq, dma_valid}, 0);

        // R3: descriptor not armed -> drop
        send(6, 1);
        hread(4, v); chk("R3 wr_ptr held", v, 0);
        hread(1, v); chk("R3 count held", v, 0);
        chk("R3 no irq", irq_seen, 0);

        arm_all();
        for (int i = 0; i < 64; i++) exp_ok[i] = 0;

        // R4 R5 R6 R11: lengths 1..8
        s = 0;
        for (int len = 1; len <= 8; len++) begin
            irq0 = irq_seen;
            send(len, len);
            for (int k = 0; k < len; k++) begin
                exp_b[s + k] = pat(len, k); exp_ok[s + k] = 1;
            end
            hread(128 + (len - 1) * 2 + 1, v);
            chk("R4 desc word1", v, {16'(16'h4000 + s), 16'(len)});
            hread(128 + (len - 1) * 2, v);
            chk("R4 empty cleared", v[15], 0);
            s += rnd4(len);
            hread(4, v); chk("R5 wr_ptr", v, s);
            hread(1, v); chk("R6 count", v, len);
            chk("R6 irq one pulse", irq_seen - irq0, 1);
        end

        // R7 R11: read back through the data port
        for (int w = 0; w < 12; w++) begin
            logic [31:0] m, e;
            hread(6, v);
            m = 0; e = 0;
            for (int b = 0; b < 4; b++)
                if (exp_ok[w * 4 + b]) begin
                    m[b*8 +: 8] = 8'hFF; e[b*8 +: 8] = exp_b[w * 4 + b];
                end
            chk("R11 data word", v & m, e);
        end
        hread(3, v); chk("R7 rd_ptr", v, 48);

        // R9: decrement on commit cycle leaves count unchanged
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(9, k); in_last = (k == 3);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        host_wr = 1'b1; host_addr = 8'd2; host_wdata = 0;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (2) @(negedge clk);
        hread(1, v); chk("R9 simultaneous inc/dec", v, 8);
        hread(4, v); chk("R5 wr_ptr after frame", v, 52);
        hwrite(2, 0);
        hread(1, v); chk("R9 decrement", v, 7);

        // R10: soft reset
        hwrite(0, 32'h1);
        hread(0, v); chk("R10 ctrl reads 0", v, 0);
        hread(1, v); chk("R10 count", v, 0);
        hread(3, v); chk("R10 rd_ptr", v, 0);
        hread(4, v); chk("R10 wr_ptr", v, 0);
        hread(5, v); chk("R10 size", v, 16384);

        // R1: fill to 64, then refusal
        arm_all();
        for (int f = 0; f < 64; f++) send(4, f);
        hread(1, v); chk("R1 count full", v, 64);
        hread(128 + 63 * 2 + 1, v); chk("R6 last slot word1", v, {16'h4000 + 16'd252, 16'd4});
        hwrite(128, 32'h0000_8000);
        irq0 = irq_seen;
        send(4, 70);
        hread(4, v); chk("R1 wr_ptr held", v, 256);
        hread(1, v); chk("R1 count held", v, 64);
        chk("R1 no irq", irq_seen - irq0, 0);
        hwrite(2, 0);
        send(4, 71);
        hread(128 + 1, v); chk("R6 index wrapped to slot 0", v, {16'h4000 + 16'd256, 16'd4});
        hread(1, v); chk("R9 count after dec+frame", v, 64);

        // R9: no underflow; R8: DMA ignored while disabled
        hwrite(0, 32'h1);
        hwrite(2, 0);
        hread(1, v); chk("R9 no underflow", v, 0);
        hwrite(7, 4);
        repeat (8) @(negedge clk);
        chk("R8 ignored when disabled", dma_n, 0);
        hread(3, v); chk("R8 rd_ptr unmoved", v, 0);

        // R2: space check, wrap and zero difference
        arm_all();
        hwrite(0, 32'h2);
        for (int f = 0; f < 10; f++) send(1514, 100 + f);
        hread(4, v); chk("R5 wr_ptr after 10 big", v, 15160);
        irq0 = irq_seen;
        send(1514, 110);
        hread(4, v); chk("R2 refused when short", v, 15160);
        hread(1, v); chk("R2 count held", v, 10);
        chk("R2 no irq", irq_seen - irq0, 0);
        hwrite(7, 73);
        repeat (80) @(negedge clk);
        chk("R8 word count", dma_n, 73);
        begin
            int errs = 0;
            for (int w = 0; w < 73; w++) begin
                logic [31:0] e;
                for (int b = 0; b < 4; b++) e[b*8 +: 8] = pat(100, w * 4 + b);
                if (dma_buf[w] != e) errs++;
            end
            chk("R8 DMA words", errs, 0);
        end
        hread(3, v); chk("R8 rd_ptr", v, 292);
        hread(0, v); chk("R8 enable cleared", v, 0);
        send(1514, 110);
        hread(128 + 10 * 2 + 1, v); chk("R4 wrapped frame word1", v, {16'h7B38, 16'h05EA});
        hread(4, v); chk("R5 wr_ptr wraps", v, 292);
        send(4, 111);
        hread(128 + 11 * 2 + 1, v); chk("R2 zero difference admits", v, {16'h4124, 16'd4});
        hread(4, v); chk("R5 wr_ptr after zero-diff frame", v, 296);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule